// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a 32-bit down-counting watchdog that escalates in two steps. When the counter runs out the first time, the block raises an interrupt and reloads the counter. If the counter runs out again before software clears that interrupt, and reset escalation is enabled, the block sends a one-cycle reset request to the system. A control bit routes the interrupt either to a maskable line or to a non-maskable line. A lock register guards the configuration: any write to it other than the key 0x1ACCE551 freezes the load, control and clear registers, and a write of the key opens them again. A debug-hold input stops the reset request from reaching the system, but the watchdog still wipes its own configuration.

The behaviour is built around a four-state machine:
- IDLE: the counter is stopped and is preloaded from the load register on every cycle.
- ARMED: the counter is running and no interrupt is pending.
- WARNED: the counter is running and the interrupt is pending.
- FIRE: the one cycle in which the reset request is made.

The machine moves between these states as follows:
- IDLE→ARMED when the enable bit is 1.
- ARMED→WARNED on an expiry.
- WARNED→ARMED on a write to the clear register.
- WARNED→FIRE on an expiry when reset escalation is enabled.
- FIRE→IDLE always.
- ARMED→IDLE and WARNED→IDLE when the enable bit is 0.

An expiry is a cycle in which the count is 0 and no load write arrives. An expiry in WARNED with escalation disabled reloads the counter, and the machine stays in WARNED.

Software reaches the registers through a single-cycle write port and a combinational read port, both with a 2-bit address:
- Address 0 holds the load value. It resets to all ones.
- Address 1 holds the control bits: bit 0 enables the counter and interrupt, bit 1 enables reset escalation, and bit 2 selects the non-maskable route.
- Address 2 clears the interrupt on a write of any data. A read of address 2 returns the pending flag in bit 0.
- Address 3 is the lock register. A read of address 3 returns 1 while locked and 0 while open.

Top module: `twostage_watchdog`

## Requirements
- R1: After reset, irq_o, nmi_o and sys_rst_o are 0, the control register reads 0, the lock register reads 0, the pending flag reads 0 and the load register reads 0xFFFFFFFF.
- R2: With load value L, a write that sets control bit 0 at clock edge E makes the interrupt output rise at edge E+L+2 and not before.
- R3: After the first expiry the counter reloads from L. If bit 1 is set and the interrupt is not cleared, sys_rst_o is 1 in exactly the cycle after edge E+2L+3.
- R4: When bit 1 is 0, later expiries with the interrupt pending never assert sys_rst_o, and the interrupt stays asserted.
- R5: A write of any data to address 2 while the interrupt is pending drops the interrupt at once and reloads the counter, so no reset is requested. The next interrupt follows L+1 edges after the clear edge.
- R6: A write to address 0 while the counter runs puts the new value into the counter at that edge, and counting continues from it. Such a write never clears a pending interrupt.
- R7: A write to address 3 with any value other than 0x1ACCE551 locks the block. While locked, writes to addresses 0, 1 and 2 are ignored. A write of 0x1ACCE551 unlocks the block. Writes to address 3 are always accepted.
- R8: The pending interrupt drives irq_o when control bit 2 is 0 and drives nmi_o when bit 2 is 1, never both.
- R9: Clearing bit 0 stops the counter and drops a pending interrupt on the next edge. Setting bit 0 again restarts the count from the load value, not from the old count.
- R10: While dbg_hold_i is 1, sys_rst_o stays 0 through a second expiry, yet the watchdog still performs its internal wipe.
- R11: The reset request lasts one cycle. After it, the control register reads 0, the block is unlocked, and the load value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 2 | Write address (0 load, 1 control, 2 clear, 3 lock) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | 32 | Combinational read data |
| dbg_hold_i | input | 1 | Debug hold: blocks the system reset request |
| irq_o | output | 1 | Maskable watchdog interrupt |
| nmi_o | output | 1 | Non-maskable watchdog interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the following about the write port:
- wr_en_i is a clean one-cycle strobe with its address and data stable across the capturing edge.
- Reset is applied before any write.

The stimulus respects this by driving every input one nanosecond after a rising edge and holding it for a full cycle, with one write per cycle. The bench sweeps small load values so that each escalation ends within a few dozen cycles. It computes every expected edge from L, alternates the interrupt route on each sweep step, and issues clears, reloads, disables and lock writes only at edges whose effect it has worked out in advance.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int unsigned WD_ADDR_W = 2;
    localparam int unsigned WD_CTRL_W = 3;

    localparam logic [WD_ADDR_W-1:0] A_LOAD  = 2'd0;
    localparam logic [WD_ADDR_W-1:0] A_CTRL  = 2'd1;
    localparam logic [WD_ADDR_W-1:0] A_CLEAR = 2'd2;
    localparam logic [WD_ADDR_W-1:0] A_LOCK  = 2'd3;

    localparam int unsigned C_EN   = 0;
    localparam int unsigned C_RSTE = 1;
    localparam int unsigned C_NMI  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WARNED,
        ST_FIRE
    } wd_state_t;
endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter int unsigned        DATA_W   = 32,
    parameter logic [DATA_W-1:0]  KEY      = 32'h1ACCE551,
    parameter logic [DATA_W-1:0]  LOAD_RST = '1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [WD_ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [WD_ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    input  logic                 wipe_i,
    input  logic                 pending_i,
    output logic                 en_o,
    output logic                 rst_en_o,
    output logic                 nmi_sel_o,
    output logic [DATA_W-1:0]    load_o,
    output logic                 load_wr_o,
    output logic                 clr_o
);
    logic [WD_CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0]    load_q;
    logic                 locked_q;
    logic                 open_w;
    logic                 ctrl_wr;

    assign open_w    = !locked_q;
    assign load_wr_o = wr_en_i && (wr_addr_i == A_LOAD)  && open_w;
    assign ctrl_wr   = wr_en_i && (wr_addr_i == A_CTRL)  && open_w;
    assign clr_o     = wr_en_i && (wr_addr_i == A_CLEAR) && open_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q   <= '0;
            load_q   <= LOAD_RST;
            locked_q <= 1'b0;
        end else if (wipe_i) begin
            ctrl_q   <= '0;
            locked_q <= 1'b0;
        end else begin
            if (load_wr_o) load_q <= wr_data_i;
            if (ctrl_wr)   ctrl_q <= wr_data_i[WD_CTRL_W-1:0];
            if (wr_en_i && (wr_addr_i == A_LOCK))
                locked_q <= (wr_data_i != KEY);
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_LOAD:  rd_data_o = load_q;
            A_CTRL:  rd_data_o[WD_CTRL_W-1:0] = ctrl_q;
            A_CLEAR: rd_data_o[0] = pending_i;
            A_LOCK:  rd_data_o[0] = locked_q;
        endcase
    end

    assign en_o      = ctrl_q[C_EN];
    assign rst_en_o  = ctrl_q[C_RSTE];
    assign nmi_sel_o = ctrl_q[C_NMI];
    assign load_o    = load_q;

    // R11: the wipe request from the state machine clears control and lock
    a_r11_wipe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wipe_i |=> (ctrl_q == '0 && !locked_q));

    // R7: while locked, configuration does not move
    a_r7_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_q && !wipe_i) |=> ($stable(ctrl_q) && $stable(load_q)));
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
    import wdt2_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rst_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_data_i,
    input  logic             clr_i,
    output logic             pending_o,
    output logic             fire_o
);
    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    assign expire = (cnt_q == '0) && !load_wr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_i) state_d = ST_ARMED;
            ST_ARMED:  if (!en_i) state_d = ST_IDLE;
                       else if (expire) state_d = ST_WARNED;
            ST_WARNED: if (!en_i) state_d = ST_IDLE;
                       else if (clr_i) state_d = ST_ARMED;
                       else if (expire && rst_en_i) state_d = ST_FIRE;
            ST_FIRE:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FIRE: cnt_q <= load_val_i;
                ST_ARMED, ST_WARNED: begin
                    if (load_wr_i)
                        cnt_q <= load_data_i;
                    else if (clr_i && state_q == ST_WARNED)
                        cnt_q <= load_val_i;
                    else if (cnt_q == '0)
                        cnt_q <= load_val_i;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        pending_o = (state_q == ST_WARNED);
        fire_o    = (state_q == ST_FIRE);
    end

    // R3: a reset request is only ever reached from the pending state
    a_r3_fire_from_warned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> $past(pending_o));

    // R11: the request is one cycle wide
    a_r11_fire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |=> !fire_o);

    // R4: no escalation while reset enable is off
    a_r4_no_fire_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && !rst_en_i) |=> !fire_o);

    // R6: a load write leaves a pending interrupt in place
    a_r6_load_keeps_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && load_wr_i && en_i && !clr_i) |=> pending_o);

    // R5: a clear drops the pending interrupt
    a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o && clr_i) |=> !pending_o);

    // R2: first expiry raises the interrupt and reloads the counter
    a_r2_first_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARMED && en_i && expire) |=> (pending_o && cnt_q == $past(load_val_i)));
endmodule

// File: rtl/twostage_watchdog.sv
module twostage_watchdog
    import wdt2_pkg::*;
#(
    parameter int unsigned       CNT_W = 32,
    parameter logic [CNT_W-1:0]  KEY   = 32'h1ACCE551
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [WD_ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    input  logic [WD_ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]     rd_data_o,
    input  logic                 dbg_hold_i,
    output logic                 irq_o,
    output logic                 nmi_o,
    output logic                 sys_rst_o
);
    logic             en, rst_en, nmi_sel, load_wr, clr, pending, fire;
    logic [CNT_W-1:0] load_val;

    wdt2_regs #(.DATA_W(CNT_W), .KEY(KEY), .LOAD_RST('1)) regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .wipe_i    (fire),
        .pending_i (pending),
        .en_o      (en),
        .rst_en_o  (rst_en),
        .nmi_sel_o (nmi_sel),
        .load_o    (load_val),
        .load_wr_o (load_wr),
        .clr_o     (clr)
    );

    wdt2_core #(.CNT_W(CNT_W)) core_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en),
        .rst_en_i    (rst_en),
        .load_val_i  (load_val),
        .load_wr_i   (load_wr),
        .load_data_i (wr_data_i),
        .clr_i       (clr),
        .pending_o   (pending),
        .fire_o      (fire)
    );

    always_comb begin
        irq_o     = pending && !nmi_sel;
        nmi_o     = pending &&  nmi_sel;
        sys_rst_o = fire && !dbg_hold_i;
    end

    // R8: the two interrupt routes never assert together
    a_r8_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({irq_o, nmi_o}));
endmodule

// File: tb/twostage_watchdog_tb_top.sv
`timescale 1ns/1ps
module twostage_watchdog_tb_top;
    localparam logic [31:0] KEY = 32'h1ACCE551;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        dbg_hold = 1'b0;
    logic        irq, nmi, sys_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    twostage_watchdog dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .dbg_hold_i(dbg_hold), .irq_o(irq), .nmi_o(nmi), .sys_rst_o(sys_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.2;
        d = rd_data;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        step(100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 irq", irq, 0); chk("R1 nmi", nmi, 0); chk("R1 sys_rst", sys_rst, 0);
        rd(1, v); chk("R1 ctrl", v, 0);
        rd(3, v); chk("R1 lock", v, 0);
        rd(2, v); chk("R1 pending", v, 0);
        rd(0, v); chk("R1 load", v, 32'hFFFF_FFFF);

        // R2 R3 R8 R11 sweep over load values, route alternating
        for (int l = 1; l <= 6; l++) begin
            logic ns;
            ns = l[0];
            wr(0, l);
            wr(1, {29'd0, ns, 1'b1, 1'b1});
            step(l + 1);
            chk("R2 no early irq", {irq, nmi}, 0);
            step(1);
            chk("R8 irq route", irq, !ns);
            chk("R8 nmi route", nmi, ns);
            step(l);
            chk("R3 no early reset", sys_rst, 0);
            step(1);
            chk("R3 reset pulse", sys_rst, 1);
            step(1);
            chk("R11 pulse ends", sys_rst, 0);
            chk("R11 irq gone", {irq, nmi}, 0);
            rd(1, v); chk("R11 ctrl wiped", v, 0);
            rd(0, v); chk("R11 load kept", v, l);
        end

        // R4 no escalation when reset enable is off
        wr(0, 3);
        wr(1, 32'd1);
        step(5);
        chk("R4 first irq", irq, 1);
        for (int i = 0; i < 12; i++) begin
            step(1);
            chk("R4 no reset", sys_rst, 0);
            chk("R4 irq held", irq, 1);
        end
        // R9 disable drops pending
        wr(1, 32'd0);
        step(1);
        chk("R9 disable drops irq", irq, 0);

        // R9 re-enable preloads
        wr(0, 10);
        wr(1, 32'd1);
        step(5);
        wr(1, 32'd0);
        step(2);
        wr(1, 32'd1);
        step(11);
        chk("R9 preload no early", irq, 0);
        step(1);
        chk("R9 preload irq", irq, 1);
        wr(1, 32'd0);
        step(1);

        // R5 clear before second expiry
        wr(0, 4);
        wr(1, 32'd3);
        step(6);
        chk("R5 irq before clear", irq, 1);
        rd(2, v); chk("R5 pending read", v, 1);
        wr(2, 32'hDEAD_BEEF);
        chk("R5 clear drops", irq, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R5 no reset", sys_rst, 0);
            step(1);
        end
        chk("R5 no early irq", irq, 0);
        step(1);
        chk("R5 next irq", irq, 1);
        wr(1, 32'd0);
        step(1);

        // R6 load write while running
        wr(0, 20);
        wr(1, 32'd1);
        step(3);
        wr(0, 3);
        step(3);
        chk("R6 no early irq", irq, 0);
        step(1);
        chk("R6 new value irq", irq, 1);
        wr(0, 50);
        chk("R6 pending kept", irq, 1);
        rd(0, v); chk("R6 load read", v, 50);
        wr(1, 32'd0);
        step(1);

        // R7 lock
        wr(3, 32'h0);
        rd(3, v); chk("R7 locked read", v, 1);
        wr(1, 32'd7);
        rd(1, v); chk("R7 ctrl ignored", v, 0);
        wr(0, 9);
        rd(0, v); chk("R7 load ignored", v, 50);
        step(60);
        chk("R7 no irq", {irq, nmi}, 0);
        wr(3, KEY);
        rd(3, v); chk("R7 unlocked read", v, 0);
        wr(3, KEY);
        rd(3, v); chk("R7 key stays open", v, 0);
        wr(0, 9);
        rd(0, v); chk("R7 write after unlock", v, 9);

        // R10 debug hold: no external reset, wipe still happens
        dbg_hold = 1'b1;
        wr(0, 2);
        wr(1, 32'd3);
        wr(3, 32'h5);
        rd(3, v); chk("R10 locked", v, 1);
        for (int i = 0; i < 9; i++) begin
            step(1);
            chk("R10 reset held", sys_rst, 0);
        end
        rd(1, v); chk("R10 ctrl wiped", v, 0);
        rd(3, v); chk("R10 lock released", v, 0);
        dbg_hold = 1'b0;

        finish_run();
    end
endmodule